// File: doc/BRIEF.md
# Microprocessor System Address Decoder

This block turns the 16-bit address bus of an 8-bit processor board into the chip selects for every memory and peripheral on it. The lower half of the map goes to one 32K RAM. The top 16K is ROM: either one 8K device repeated twice, or two 8K devices side by side. A packed 128-byte I/O area at 8000h is divided into eight windows of 16 registers each, and everything between 8080h and BFFFh is left empty.

The decode is purely combinational, and every select is active low. The RAM select and a separate RAM write strobe are qualified by a clock-phase input, so the RAM is never enabled while the bus is still settling. The ROM and I/O selects depend on the address alone. A flag marks addresses that no device answers. A parameter chooses between the single-ROM (mirrored) map and the split two-ROM map.

The I/O windows are assigned as follows: window 0 drives the display, window 1 the parallel interface adapter, window 2 the serial interface, and windows 3 to 7 are spare.

Top module: `sys_addr_decoder`

## Requirements
- R1: `ram_sel_n` is 0 exactly when the address is below 8000h and `phase` is 1; otherwise it is 1.
- R2: `ram_wr_n` is 0 exactly when the address is below 8000h, `phase` is 1 and `rw_n` is 0 (write); `rw_n` = 1 means read and keeps `ram_wr_n` at 1.
- R3: `rom1_sel_n` is 0 for every address from E000h to FFFFh, in both ROM configurations.
- R4: With `HAS_ROM2` = 1, addresses C000h to DFFFh (A13 = 0) drive `rom2_sel_n` to 0 and hold `rom1_sel_n` at 1.
- R5: With `HAS_ROM2` = 0, `rom1_sel_n` is 0 across all of C000h to FFFFh, and `rom2_sel_n` stays at 1 for every address.
- R6: `io_sel_n[k]` is 0 exactly when the address lies in 8000h to 807Fh and address bits 6..4 equal k. Each window therefore spans 16 consecutive addresses starting at 8000h + 16*k.
- R7: Addresses 8080h to BFFFh drive every select output to 1.
- R8: For any address, `phase` and `rw_n`, at most one of `ram_sel_n`, `rom1_sel_n`, `rom2_sel_n` and the eight `io_sel_n` bits is 0.
- R9: `unmapped` is 1 exactly for addresses 8080h to BFFFh, and it does not depend on `phase` or `rw_n`.
- R10: `phase` and `rw_n` have no effect on `rom1_sel_n`, `rom2_sel_n` or `io_sel_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | Processor address bus |
| rw_n | input | 1 | 1 = read cycle, 0 = write cycle |
| phase | input | 1 | Clock-phase qualifier; RAM may be enabled only while it is 1 |
| ram_sel_n | output | 1 | RAM chip select, active low |
| ram_wr_n | output | 1 | RAM write strobe, active low |
| rom1_sel_n | output | 1 | Primary ROM select, active low |
| rom2_sel_n | output | 1 | Optional second ROM select, active low |
| io_sel_n | output | 8 | One active-low select per 16-byte I/O window |
| unmapped | output | 1 | High when no device answers the address |

## Verification
Two of the block's functions can act in the same cycle: the phase gating of the RAM path and the address decode of the ROM and I/O paths. Both respond to every bus cycle. If the two interfered, a select could appear twice, or a ROM or I/O select could follow `phase`. The bench sweeps every address under both phase levels and random read/write values, in two instances that differ only in the ROM configuration. It checks each output against a region table computed from numeric address ranges. It also counts the active selects, to confirm that the phase-gated RAM path and the ungated paths never overlap and that exactly the empty region raises `unmapped`.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int ADDR_W    = 16;
  localparam int IO_WIN    = 8;
  localparam int IO_IDX_W  = $clog2(IO_WIN);
  localparam int IO_SPAN_W = 4;                           // 16 registers per window
  localparam int IO_TOP    = IO_SPAN_W + IO_IDX_W;        // first bit above I/O area
  localparam int ROM_SPLIT = ADDR_W - 3;                  // bit that halves the ROM area

  // lower half of the map belongs to RAM
  function automatic logic is_ram_zone(input logic [ADDR_W-1:0] a);
    return ~a[ADDR_W-1];
  endfunction

  // top quarter belongs to ROM
  function automatic logic is_rom_zone(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1] & a[ADDR_W-2];
  endfunction

  // packed I/O block: top bit set, everything between it and the window index clear
  function automatic logic is_io_zone(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1] & ~(|a[ADDR_W-2:IO_TOP]);
  endfunction

  function automatic logic [IO_IDX_W-1:0] io_index(input logic [ADDR_W-1:0] a);
    return a[IO_TOP-1:IO_SPAN_W];
  endfunction

  // gap between I/O block and ROM
  function automatic logic is_gap_zone(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1] & ~a[ADDR_W-2] & (|a[ADDR_W-3:IO_TOP]);
  endfunction
endpackage

// File: rtl/sad_io_windows.sv
module sad_io_windows
  import sad_pkg::*;
#(
  parameter int N_WIN = IO_WIN,
  localparam int IDX_W = $clog2(N_WIN)
) (
  input  logic             enable,
  input  logic [IDX_W-1:0] idx,
  output logic [N_WIN-1:0] sel_n
);
  logic [N_WIN-1:0] hit;

  for (genvar k = 0; k < N_WIN; k++) begin : g_win
    assign hit[k] = enable & (idx == IDX_W'(k));
  end

  assign sel_n = ~hit;

  always_comb begin
    // R6: an enabled block lights exactly one window, a disabled one none
    p_io_onehot_r6: assert (enable ? $onehot(hit) : (hit == '0))
      else $error("io window decode broken idx=%0d en=%0b", idx, enable);
  end
endmodule

// File: rtl/sad_rom_select.sv
module sad_rom_select #(
  parameter bit HAS_ROM2 = 1'b0
) (
  input  logic zone,
  input  logic upper_half,
  output logic rom1_sel_n,
  output logic rom2_sel_n
);
  logic pick_upper;

  // single device answers both halves (mirror); split map uses the halving bit
  assign pick_upper = HAS_ROM2 ? upper_half : 1'b1;
  assign rom1_sel_n = ~(zone & pick_upper);

  if (HAS_ROM2) begin : g_split
    assign rom2_sel_n = ~(zone & ~upper_half);
  end else begin : g_mirror
    assign rom2_sel_n = 1'b1;
  end

  always_comb begin
    // R4 / R5: the two ROM selects are never low together
    p_rom_exclusive_r4: assert (rom1_sel_n | rom2_sel_n)
      else $error("both ROM selects active");
    // R3: the vector half always reaches the primary ROM
    p_rom_vectors_r3: assert (!(zone && upper_half) || !rom1_sel_n)
      else $error("primary ROM missing in upper half");
  end
endmodule

// File: rtl/sys_addr_decoder.sv
module sys_addr_decoder
  import sad_pkg::*;
#(
  parameter bit HAS_ROM2 = 1'b0
) (
  input  logic [15:0] addr,
  input  logic        rw_n,
  input  logic        phase,
  output logic        ram_sel_n,
  output logic        ram_wr_n,
  output logic        rom1_sel_n,
  output logic        rom2_sel_n,
  output logic [7:0]  io_sel_n,
  output logic        unmapped
);
  // named zone wires, brought out for the checks below
  logic ram_zone, rom_zone, io_zone, gap_zone;
  logic ram_gated;

  assign ram_zone = is_ram_zone(addr);
  assign rom_zone = is_rom_zone(addr);
  assign io_zone  = is_io_zone(addr);
  assign gap_zone = is_gap_zone(addr);

  // RAM path: only while the phase qualifier is high
  assign ram_gated = ram_zone & phase;
  assign ram_sel_n = ~ram_gated;
  assign ram_wr_n  = ~(ram_gated & ~rw_n);

  sad_io_windows #(.N_WIN(IO_WIN)) u_io (
    .enable (io_zone),
    .idx    (io_index(addr)),
    .sel_n  (io_sel_n)
  );

  sad_rom_select #(.HAS_ROM2(HAS_ROM2)) u_rom (
    .zone       (rom_zone),
    .upper_half (addr[ROM_SPLIT]),
    .rom1_sel_n (rom1_sel_n),
    .rom2_sel_n (rom2_sel_n)
  );

  assign unmapped = gap_zone;

  always_comb begin
    // R8: never more than one device enabled
    p_single_select_r8: assert ($countones({~ram_sel_n, ~rom1_sel_n, ~rom2_sel_n, ~io_sel_n}) <= 1)
      else $error("several selects at addr %h", addr);
    // R9: the empty flag and any select exclude each other
    p_gap_quiet_r9: assert (!unmapped || ({ram_sel_n, rom1_sel_n, rom2_sel_n, io_sel_n} == '1))
      else $error("select inside empty region at %h", addr);
    // R2: a write strobe implies the RAM select
    p_wr_inside_sel_r2: assert (ram_wr_n || !ram_sel_n)
      else $error("write strobe without select at %h", addr);
    // the four zones partition the address space
    p_zone_cover_r7: assert ($onehot({ram_zone, rom_zone, io_zone, gap_zone}))
      else $error("zone overlap or hole at %h", addr);
  end
endmodule

// File: tb/test_sys_addr_decoder.sv
module test_sys_addr_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic rw_n = 1'b1;
  logic phase = 1'b0;

  logic ram_a, wr_a, r1_a, r2_a, un_a;
  logic ram_b, wr_b, r1_b, r2_b, un_b;
  logic [7:0] io_a, io_b;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_addr_decoder #(.HAS_ROM2(1'b0)) i_sys_addr_decoder (
    .addr(addr), .rw_n(rw_n), .phase(phase),
    .ram_sel_n(ram_a), .ram_wr_n(wr_a), .rom1_sel_n(r1_a), .rom2_sel_n(r2_a),
    .io_sel_n(io_a), .unmapped(un_a));

  sys_addr_decoder #(.HAS_ROM2(1'b1)) i_sys_addr_decoder_split (
    .addr(addr), .rw_n(rw_n), .phase(phase),
    .ram_sel_n(ram_b), .ram_wr_n(wr_b), .rom1_sel_n(r1_b), .rom2_sel_n(r2_b),
    .io_sel_n(io_b), .unmapped(un_b));

  // expected values from numeric address ranges
  function automatic logic e_ram(int a, logic ph); return (a < 32768) && ph; endfunction
  function automatic logic e_wr(int a, logic ph, logic rw); return (a < 32768) && ph && !rw; endfunction
  function automatic logic e_rom1(int a, bit split);
    return split ? (a >= 'hE000) : (a >= 'hC000);
  endfunction
  function automatic logic e_rom2(int a, bit split);
    return split && (a >= 'hC000) && (a < 'hE000);
  endfunction
  function automatic logic [7:0] e_io(int a);
    logic [7:0] v = '0;
    if (a >= 'h8000 && a < 'h8080) v[(a - 'h8000) / 16] = 1'b1;
    return v;
  endfunction
  function automatic logic e_gap(int a); return a >= 'h8080 && a < 'hC000; endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr=%h phase=%0b rw_n=%0b actual=%h expected=%h",
               req, addr, phase, rw_n, act, exp);
    end
  endtask

  task automatic check_one(input bit split);
    int a = int'(addr);
    logic rs, wr, r1, r2, un;
    logic [7:0] io;
    if (split) begin rs = ram_b; wr = wr_b; r1 = r1_b; r2 = r2_b; io = io_b; un = un_b; end
    else       begin rs = ram_a; wr = wr_a; r1 = r1_a; r2 = r2_a; io = io_a; un = un_a; end
    chk("R1 ram select", {7'd0, rs}, {7'd0, ~e_ram(a, phase)});
    chk("R2 ram write", {7'd0, wr}, {7'd0, ~e_wr(a, phase, rw_n)});
    chk(split ? "R3/R4 rom1" : "R3/R5 rom1", {7'd0, r1}, {7'd0, ~e_rom1(a, split)});
    chk(split ? "R4 rom2" : "R5 rom2", {7'd0, r2}, {7'd0, ~e_rom2(a, split)});
    chk("R6 io windows", io, ~e_io(a));
    chk("R9 unmapped", {7'd0, un}, {7'd0, e_gap(a)});
    chk("R8 select count", 8'($countones({~rs, ~r1, ~r2, ~io}) > 1), 8'd0);
    if (e_gap(a)) chk("R7 empty region", {rs, r1, r2, io[4:0]}, 8'hFF);
  endtask

  task automatic apply(input logic [15:0] a, input logic ph, input logic rw);
    addr = a; phase = ph; rw_n = rw;
    #2;
    check_one(1'b0);
    check_one(1'b1);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5AD0_1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: phase low, RAM quiet at address 0
    #1;
    chk("R1 reset ram quiet", {7'd0, ram_a}, 8'd1);
    chk("R2 reset write quiet", {7'd0, wr_a}, 8'd1);
    rst = 1'b0;

    // directed region boundaries
    apply(16'h0000, 1'b1, 1'b0);
    apply(16'h7FFF, 1'b1, 1'b0);
    apply(16'h7FFF, 1'b0, 1'b0);
    apply(16'h8000, 1'b1, 1'b1);
    apply(16'h800F, 1'b1, 1'b1);
    apply(16'h8010, 1'b1, 1'b1);
    apply(16'h8020, 1'b1, 1'b1);
    apply(16'h807F, 1'b1, 1'b1);
    apply(16'h8080, 1'b1, 1'b1);
    apply(16'hBFFF, 1'b1, 1'b1);
    apply(16'hC000, 1'b0, 1'b1);
    apply(16'hDFFF, 1'b1, 1'b1);
    apply(16'hE000, 1'b0, 1'b0);
    apply(16'hFFFA, 1'b1, 1'b1);
    apply(16'hFFFF, 1'b1, 1'b1);

    // R10: phase and rw_n toggled on fixed ROM / I/O addresses
    for (int k = 0; k < 4; k++) begin
      apply(16'h8025, k[0], k[1]);
      chk("R10 io stable vs phase", io_a, 8'hFB);
      apply(16'hF123, k[0], k[1]);
      chk("R10 rom stable vs phase", {6'd0, r1_b, r2_b}, 8'h01);
    end

    // exhaustive sweep, random phase / direction
    for (int a = 0; a < 65536; a++) begin
      apply(16'(a), 1'($urandom), 1'($urandom));
    end

    // random mixed traffic
    for (int n = 0; n < 4000; n++) begin
      apply(16'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule